// File: doc/BRIEF.md
# Comma-Aligned Deserializer Word Aligner

This block turns a recovered serial bit stream into 10-bit words. Bits arrive one per system clock cycle in which the bit strobe is high. The block keeps the last ten received bits and checks them on every bit for the comma prefix. When it finds the prefix with alignment enabled, it moves the word boundary so that the comma becomes a word of its own. The bits of any partly collected word are dropped at that point.

A half-rate word clock and its complement go with the words. A new word is presented on each rising edge of either clock, so one clock period spans twenty bit times. A comma-detect flag marks the word that carries the comma, and comma words are always placed on the phase where the complement clock rises. A loopback control feeds the local transmit bit back into the receive path and holds the transmit output high.

The serial input has a valid strobe and no ready. A line cannot stall, so every strobed bit is consumed, and a low strobe simply means no bit in that cycle. The word output is a one-cycle `word_vld` strobe with no back-pressure: the consumer must take each word in the cycle it is strobed. The word itself stays on `word_q` until the next strobe.

Top module: `comma_deser_align`

## Requirements
- R1: A synchronous active-high `rst` drives `word_q` to 0, `word_vld` low, `comma_det` low, `wclk` low and `wclk_n` high. It also clears the bit count and the received-bit window.
- R2: With no comma seen, a word is emitted after every 10 strobed bits. `word_vld` is high for one cycle, in the cycle after the edge that takes the tenth bit. `word_q[0]` holds the earliest bit in time, and `word_q` does not change between strobes.
- R3: A comma is a 10-bit window whose bits 0 to 6 are 0,0,1,1,1,1,1 in that order, so `word_q[6:0]` == 7'b1111100. Bits 7 to 9 are don't-care.
- R4: With `align_en` high, a bit that completes a comma window ends the current word at once. The comma window is emitted as the next word, and the following words are counted from the bit after it. Any partial word collected before it is discarded.
- R5: `comma_det` is high together with the emitted comma word. It stays high until the next word strobe and is low for all other words.
- R6: `wclk` toggles on every normally counted word, and `wclk_n` is always its complement. A comma word is always emitted with `wclk` low, on the rising edge of `wclk_n`.
- R7: With `align_en` low, the word boundary is kept unchanged and `comma_det` stays low, even when comma patterns arrive.
- R8: With `loopback` high, received bits come from `tx_bit` instead of `rx_bit`, and `tx_out` is 1. With `loopback` low, `tx_out` equals `tx_bit`.
- R9: A cycle with `bit_vld` low advances nothing: no word strobe follows it and no output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_vld | input | 1 | Strobe: a serial bit is present this cycle |
| rx_bit | input | 1 | Serial receive bit |
| tx_bit | input | 1 | Local transmit bit |
| loopback | input | 1 | Feed the transmit bit into the receiver and hold the transmit output high |
| align_en | input | 1 | Enables comma detection and word re-alignment |
| tx_out | output | 1 | Transmit output |
| word_q | output | WORD_W | Received word, bit 0 earliest in time |
| word_vld | output | 1 | One-cycle strobe for a new word |
| wclk | output | 1 | Half-rate word clock |
| wclk_n | output | 1 | Complement of the word clock |
| comma_det | output | 1 | High while the presented word is a detected comma |

## Verification
A stream of non-comma data words shows the plain ten-bit framing and the bit order. The same data behind slips of three, four and two bits, each followed by a comma, shows re-alignment from different offsets and that the comma lands on the complement phase. A comma with all-ones tail bits shows the tail is ignored. A repeat with alignment disabled shows that the boundary is held and no flag is raised. Long runs of random bits with random strobe gaps compare every output against a behavioural model each cycle, and the loopback run shows the receive source switching along with the forced transmit output.

// File: rtl/cda_pkg.sv
`timescale 1ns/1ps
package cda_pkg;
  localparam int unsigned CDA_WORD_W = 10;
  localparam int unsigned CDA_PFX_W  = 7;
  // comma prefix, bit 0 = earliest bit: 0,0,1,1,1,1,1
  localparam logic [CDA_PFX_W-1:0] CDA_PFX = 7'b1111100;

  // word phase: TRUE words rise with wclk, COMP words with wclk_n
  typedef enum logic {
    PH_COMP = 1'b0,
    PH_TRUE = 1'b1
  } word_phase_e;
endpackage

// File: rtl/cda_src_sel.sv
`timescale 1ns/1ps
module cda_src_sel (
  input  logic rx_bit,
  input  logic tx_bit,
  input  logic loopback,
  output logic sel_bit,
  output logic tx_out
);
  // internal wrap path: receiver listens to the local transmitter
  assign sel_bit = loopback ? tx_bit : rx_bit;
  assign tx_out  = loopback ? 1'b1   : tx_bit;
endmodule

// File: rtl/cda_bit_window.sv
`timescale 1ns/1ps
module cda_bit_window import cda_pkg::*; #(
  parameter int unsigned WORD_W = CDA_WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_vld,
  input  logic              bit_in,
  output logic [WORD_W-1:0] cand
);
  // WORD_W-1 stored bits plus the arriving bit form the candidate word
  logic [WORD_W-2:0] hist_q;

  assign cand = {bit_in, hist_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
    end else if (bit_vld) begin
      hist_q <= cand[WORD_W-1:1];
    end
  end
endmodule

// File: rtl/cda_comma_match.sv
`timescale 1ns/1ps
module cda_comma_match import cda_pkg::*; #(
  parameter int unsigned           PFX_W = CDA_PFX_W,
  parameter logic [PFX_W-1:0]      PFX   = CDA_PFX
) (
  input  logic [PFX_W-1:0] lead,
  output logic             hit
);
  logic [PFX_W-1:0] eq;

  for (genvar i = 0; i < PFX_W; i++) begin : g_bit
    assign eq[i] = (lead[i] == PFX[i]);
  end

  assign hit = &eq;
endmodule

// File: rtl/cda_framer.sv
`timescale 1ns/1ps
module cda_framer import cda_pkg::*; #(
  parameter int unsigned WORD_W = CDA_WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_vld,
  input  logic              align_en,
  input  logic [WORD_W-1:0] cand,
  input  logic              hit,
  output logic [WORD_W-1:0] word_q,
  output logic              word_vld,
  output logic              comma_det,
  output word_phase_e       phase
);
  localparam int unsigned        CNT_W    = $clog2(WORD_W);
  localparam logic [CNT_W-1:0]   CNT_LAST = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             realign;
  logic             at_end;

  assign realign = align_en && hit;
  assign at_end  = (cnt_q == CNT_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      word_q    <= '0;
      word_vld  <= 1'b0;
      comma_det <= 1'b0;
      phase     <= PH_COMP;
    end else begin
      word_vld <= 1'b0;
      if (bit_vld) begin
        if (realign) begin
          // comma closes the word now; partial bits are dropped
          word_q    <= cand;
          word_vld  <= 1'b1;
          comma_det <= 1'b1;
          phase     <= PH_COMP;
          cnt_q     <= '0;
        end else if (at_end) begin
          word_q    <= cand;
          word_vld  <= 1'b1;
          comma_det <= 1'b0;
          phase     <= (phase == PH_TRUE) ? PH_COMP : PH_TRUE;
          cnt_q     <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/comma_deser_align.sv
`timescale 1ns/1ps
module comma_deser_align import cda_pkg::*; #(
  parameter int unsigned      WORD_W = CDA_WORD_W,
  parameter int unsigned      PFX_W  = CDA_PFX_W,
  parameter logic [PFX_W-1:0] PFX    = CDA_PFX
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_vld,
  input  logic              rx_bit,
  input  logic              tx_bit,
  input  logic              loopback,
  input  logic              align_en,
  output logic              tx_out,
  output logic [WORD_W-1:0] word_q,
  output logic              word_vld,
  output logic              wclk,
  output logic              wclk_n,
  output logic              comma_det
);
  logic              sel_bit;
  logic [WORD_W-1:0] cand;
  logic              hit;
  word_phase_e       phase;

  cda_src_sel u_src (
    .rx_bit   (rx_bit),
    .tx_bit   (tx_bit),
    .loopback (loopback),
    .sel_bit  (sel_bit),
    .tx_out   (tx_out)
  );

  cda_bit_window #(.WORD_W(WORD_W)) u_win (
    .clk     (clk),
    .rst     (rst),
    .bit_vld (bit_vld),
    .bit_in  (sel_bit),
    .cand    (cand)
  );

  cda_comma_match #(.PFX_W(PFX_W), .PFX(PFX)) u_match (
    .lead (cand[PFX_W-1:0]),
    .hit  (hit)
  );

  cda_framer #(.WORD_W(WORD_W)) u_frm (
    .clk       (clk),
    .rst       (rst),
    .bit_vld   (bit_vld),
    .align_en  (align_en),
    .cand      (cand),
    .hit       (hit),
    .word_q    (word_q),
    .word_vld  (word_vld),
    .comma_det (comma_det),
    .phase     (phase)
  );

  assign wclk   = (phase == PH_TRUE);
  assign wclk_n = ~wclk;
endmodule

// File: rtl/cda_checker.sv
`timescale 1ns/1ps
module cda_checker import cda_pkg::*; #(
  parameter int unsigned      WORD_W = CDA_WORD_W,
  parameter int unsigned      PFX_W  = CDA_PFX_W,
  parameter logic [PFX_W-1:0] PFX    = CDA_PFX
) (
  input logic              clk,
  input logic              rst,
  input logic              bit_vld,
  input logic              loopback,
  input logic              align_en,
  input logic              tx_out,
  input logic [WORD_W-1:0] word_q,
  input logic              word_vld,
  input logic              wclk,
  input logic              comma_det
);
  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (word_q == '0) && !comma_det && !wclk && !word_vld);

  a_r2_word_held: assert property (@(posedge clk) disable iff (rst)
    !word_vld |-> $stable(word_q) && $stable(comma_det) && $stable(wclk));

  a_r3_flag_has_prefix: assert property (@(posedge clk) disable iff (rst)
    (word_vld && comma_det) |-> (word_q[PFX_W-1:0] == PFX));

  a_r6_comma_on_comp: assert property (@(posedge clk) disable iff (rst)
    comma_det |-> !wclk);

  a_r6_phase_toggles: assert property (@(posedge clk) disable iff (rst)
    (word_vld && !comma_det) |-> (wclk != $past(wclk)));

  a_r7_no_flag_disabled: assert property (@(posedge clk) disable iff (rst)
    (word_vld && !$past(align_en)) |-> !comma_det);

  a_r8_tx_forced: assert property (@(posedge clk) disable iff (rst)
    loopback |-> tx_out);

  a_r9_idle_no_word: assert property (@(posedge clk) disable iff (rst)
    !$past(bit_vld) |-> !word_vld);
endmodule

bind comma_deser_align cda_checker #(.WORD_W(WORD_W), .PFX_W(PFX_W), .PFX(PFX)) u_chk (.*);

// File: tb/sim_comma_deser_align.sv
`timescale 1ns/1ps
module sim_comma_deser_align;
  localparam int W = 10;
  localparam logic [W-1:0] COMMA_A = 10'h17C; // tail 0,1,0
  localparam logic [W-1:0] COMMA_B = 10'h3FC; // tail 1,1,1
  localparam logic [W-1:0] D1      = 10'h155;
  localparam logic [W-1:0] D2      = 10'h0F0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_vld = 1'b0, rx_bit = 1'b0, tx_bit = 1'b0;
  logic loopback = 1'b0, align_en = 1'b1;
  logic tx_out, word_vld, wclk, wclk_n, comma_det;
  logic [W-1:0] word_q;

  always #4 clk = ~clk; // 125 MHz

  comma_deser_align u0 (
    .clk(clk), .rst(rst), .bit_vld(bit_vld), .rx_bit(rx_bit), .tx_bit(tx_bit),
    .loopback(loopback), .align_en(align_en), .tx_out(tx_out), .word_q(word_q),
    .word_vld(word_vld), .wclk(wclk), .wclk_n(wclk_n), .comma_det(comma_det)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // behavioural reference, updated on every clock edge
  logic [W-1:0] m_win, m_word;
  int  m_cnt;
  bit  m_vld, m_det, m_ph, live = 1'b0;
  always @(posedge clk) begin
    logic b;
    live = 1'b1;
    if (rst) begin
      m_win = '0; m_word = '0; m_cnt = 0; m_vld = 0; m_det = 0; m_ph = 0;
    end else begin
      m_vld = 0;
      if (bit_vld) begin
        b = loopback ? tx_bit : rx_bit;
        m_win = {b, m_win[W-1:1]};
        if (align_en && m_win[6:0] == 7'b1111100) begin
          m_word = m_win; m_vld = 1; m_det = 1; m_ph = 0; m_cnt = 0;
        end else if (m_cnt == W - 1) begin
          m_word = m_win; m_vld = 1; m_det = 0; m_ph = !m_ph; m_cnt = 0;
        end else begin
          m_cnt++;
        end
      end
    end
  end

  // compare every cycle, between edges
  always @(negedge clk) begin
    if (live && !done) begin
      chk(word_q == m_word, "R2", "word_q", word_q, m_word);
      chk(word_vld == m_vld, "R2", "word_vld", word_vld, m_vld);
      chk(wclk == m_ph, "R6", "wclk", wclk, m_ph);
      chk(wclk_n == !m_ph, "R6", "wclk_n", wclk_n, !m_ph);
      chk(comma_det == m_det, "R5", "comma_det", comma_det, m_det);
      chk(tx_out == (loopback ? 1'b1 : tx_bit), "R8", "tx_out", tx_out,
          loopback ? 1 : tx_bit);
    end
  end

  // capture emitted words: {comma_det, wclk, word}
  logic [W+1:0] cap[$];
  always @(negedge clk) if (!rst && word_vld) cap.push_back({comma_det, wclk, word_q});

  bit gaps = 1'b1;
  task automatic put_bit(input logic b);
    if (gaps && $urandom_range(0, 3) == 0) begin
      @(posedge clk); #1 bit_vld = 1'b0;
    end
    @(posedge clk); #1;
    bit_vld = 1'b1;
    if (loopback) begin
      tx_bit = b; rx_bit = 1'($urandom_range(0, 1));
    end else begin
      rx_bit = b; tx_bit = 1'($urandom_range(0, 1));
    end
  endtask

  task automatic send_word(input logic [W-1:0] w);
    for (int i = 0; i < W; i++) put_bit(w[i]);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1 bit_vld = 1'b0;
    end
  endtask

  // find the first flagged word in cap and check it and its successors
  task automatic check_after_comma(input string req, input logic [W-1:0] cw,
                                   input logic [W-1:0] n1, input logic [W-1:0] n2,
                                   input bit check_n2);
    int k = -1;
    for (int i = 0; i < cap.size(); i++) if (k < 0 && cap[i][W+1]) k = i;
    chk(k >= 0, req, "comma flagged", k, 0);
    if (k >= 0) begin
      chk(cap[k][W-1:0] == cw, req, "comma word", cap[k][W-1:0], cw);
      chk(cap[k][W] == 1'b0, "R6", "comma on comp phase", cap[k][W], 0);
      chk(k + 1 < cap.size() && cap[k+1][W-1:0] == n1, "R4", "word after comma",
          (k + 1 < cap.size()) ? cap[k+1][W-1:0] : -1, n1);
      if (check_n2)
        chk(k + 2 < cap.size() && cap[k+2][W-1:0] == n2 && !cap[k+2][W+1],
            "R4", "second word after comma",
            (k + 2 < cap.size()) ? cap[k+2][W-1:0] : -1, n2);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [W-1:0] held;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1: state right after reset
    chk(word_q == '0 && !word_vld && !comma_det && !wclk && wclk_n, "R1",
        "reset outputs", {word_q, word_vld, comma_det, wclk, wclk_n}, 1);

    // R4/R5/R3: slip of 3 then comma, data follows aligned
    cap.delete();
    put_bit(1); put_bit(1); put_bit(1);
    send_word(COMMA_A); send_word(D1); send_word(D2); idle(3);
    check_after_comma("R4", COMMA_A, D1, D2, 1'b1);
    chk(cap.size() >= 2 && cap[cap.size()-1][W] != cap[cap.size()-2][W], "R6",
        "phase alternates", cap.size(), 2);

    // R3: tail bits don't care, re-align from slip of 4
    cap.delete();
    put_bit(1); put_bit(0); put_bit(1); put_bit(1);
    send_word(COMMA_B); send_word(D1); idle(3);
    check_after_comma("R3", COMMA_B, D1, D2, 1'b0);

    // R7: alignment frozen, slip of 3 then comma
    cap.delete();
    align_en = 1'b0;
    put_bit(1); put_bit(1); put_bit(0);
    send_word(COMMA_A); send_word(D1); send_word(D2); idle(3);
    begin
      bit any_det = 0, any_comma = 0;
      foreach (cap[i]) begin
        if (cap[i][W+1]) any_det = 1;
        if (cap[i][W-1:0] == COMMA_A) any_comma = 1;
      end
      chk(!any_det, "R7", "no flag while disabled", any_det, 0);
      chk(!any_comma, "R7", "boundary held", any_comma, 0);
    end
    align_en = 1'b1;

    // R9: no strobe, nothing changes
    held = word_q;
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); #1 bit_vld = 1'b0;
      rx_bit = 1'($urandom_range(0, 1));
      @(negedge clk);
      chk(!word_vld && word_q == held, "R9", "idle cycle", word_q, held);
    end

    // R8: loopback, comma and data come through tx_bit
    cap.delete();
    loopback = 1'b1;
    put_bit(1); put_bit(1);
    send_word(COMMA_A); send_word(D2); idle(3);
    chk(tx_out == 1'b1, "R8", "tx_out forced", tx_out, 1);
    check_after_comma("R8", COMMA_A, D2, D2, 1'b0);
    loopback = 1'b0;

    // R2: long random stream with gaps, model compares each cycle
    for (int i = 0; i < 400; i++) put_bit(1'($urandom_range(0, 1)));
    align_en = 1'b0;
    for (int i = 0; i < 200; i++) put_bit(1'($urandom_range(0, 1)));
    align_en = 1'b1;
    gaps = 1'b0;
    send_word(D1); send_word(D2);
    idle(4);
    finish_run();
  end
endmodule